// File: doc/BRIEF.md
# Double-Precision Special-Operand and NaN Resolver

This block sits beside the arithmetic datapath of a binary64 floating-point unit. For each operation it decides whether the result is set by the operands' special values rather than by arithmetic. Such a result is a propagated NaN, the default NaN for an invalid operation, or the negative zero root. When one applies, the block supplies the result and raises a flag that tells the surrounding unit to bypass its rounded datapath output. It also reports an invalid-operation condition.

Operand A is the destination operand and operand B is the source operand. A policy input selects how two NaN inputs are resolved. Destination-priority policy always takes operand A. Magnitude-priority policy takes the NaN with the larger payload, which makes the result independent of operand order. Inputs are taken with a valid strobe, and the registered result follows one clock later.

Top module: `fpn_special_resolver`

## Requirements
- R1: Opcodes are add=0, subtract=1, multiply=2, divide=3, square root=4; codes 5 to 7 are never special. For a two-operand opcode with exactly one NaN operand (exponent all ones, significand nonzero), the result has that operand's sign, exponent 0x7FF, significand bit 51 (quiet bit) forced to 1, and bits 50:0 copied from that operand.
- R2: With policy 0 (destination priority) and both operands NaN, the sign and bits 50:0 come from operand A, so swapping A and B changes the result.
- R3: With policy 1 (magnitude priority) and both operands NaN, the operand with the larger bits 50:0 (unsigned, sign and quiet bit ignored) supplies sign and payload; on a tie operand A is used.
- R4: Square root uses only operand B; a NaN B propagates with B's sign and payload as in R1, and a NaN in operand A has no effect.
- R5: Multiplying an infinity by a zero in either order returns the default NaN 0xFFF8000000000000 with the invalid flag set.
- R6: Adding infinities of opposite sign, or subtracting infinities of equal sign, returns the default NaN with invalid set; adding equal-sign infinities is not special.
- R7: Dividing zero by zero, or infinity by infinity of any signs, returns the default NaN with invalid set.
- R8: The square root of a negative nonzero non-NaN B, including negative infinity, returns the default NaN with invalid set; the square root of -0 returns 0x8000000000000000 with special set and invalid clear.
- R9: An input NaN whose quiet bit is 0 (signalling) sets invalid while still propagating quieted; NaN propagation takes priority over the invalid cases of R5 to R8, and a quiet NaN sets no invalid flag.
- R10: When no NaN and no invalid case applies, the special flag, the invalid flag and the result are all zero.
- R11: The output valid is high exactly in the cycle after a clock edge at which the input valid was high; after an edge with the input valid low, all outputs are zero.
- R12: A synchronous active-low reset clears all outputs, and reset overrides a simultaneous input valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Operands and opcode are present |
| i_op | input | 3 | Operation code (R1) |
| i_policy | input | 1 | Two-NaN policy: 0 destination priority, 1 magnitude priority |
| i_a | input | 64 | Destination operand, binary64 |
| i_b | input | 64 | Source operand, binary64 |
| o_valid | output | 1 | Registered result valid |
| o_special | output | 1 | Result is special; bypass the arithmetic result |
| o_invalid | output | 1 | Invalid-operation condition |
| o_result | output | 64 | Special result, zero when not special |

## Verification
The hardest case to reach is a two-NaN input under magnitude priority, where the two payloads differ only in low bits or are equal. Here the winner must come from the unsigned payload comparison with the quiet bit removed, and not from sign or operand position. The stimulus table sends the same pair in both operand orders. It adds an exact tie with opposite signs, and a signalling NaN whose raw payload beats a quiet NaN that has an empty payload. Further vectors set a NaN against an infinity-times-zero pattern, to show that propagation outranks the invalid-operation rules.

// File: rtl/fpn_pkg.sv
// Package fpn_pkg
// Shared opcode and policy encodings and the per-operand class record used
// by the special-operand resolver. Assumes binary64-style layout in users.
package fpn_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4
    } fpn_op_e;

    typedef enum logic {
        POL_DEST = 1'b0,
        POL_MAG  = 1'b1
    } fpn_pol_e;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } fpn_cls_t;

endpackage

// File: rtl/fpn_classify.sv
// Module fpn_classify
// Decodes one IEEE-style operand into sign / NaN / signalling NaN /
// infinity / zero flags. Purely combinational.
// Assumes the quiet bit is the most significant significand bit.
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] i_val,
    output fpn_cls_t              o_cls
);
    localparam int MSB = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // Split fields and derive class flags.
    always_comb begin
        exp_f   = i_val[MSB-1:FRAC_W];
        frac_f  = i_val[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
        o_cls.sign    = i_val[MSB];
        o_cls.is_nan  = exp_max && frac_nz;
        o_cls.is_snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
        o_cls.is_inf  = exp_max && !frac_nz;
        o_cls.is_zero = exp_min && !frac_nz;
    end
endmodule

// File: rtl/fpn_nan_pick.sv
// Module fpn_nan_pick
// Chooses which NaN operand is propagated and builds the quieted NaN.
// Unary operations look only at operand B. With two NaNs, policy
// destination-priority takes A; magnitude-priority takes the larger
// payload (quiet bit excluded) with ties to A.
module fpn_nan_pick
    import fpn_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] i_a,
    input  logic [EXP_W+FRAC_W:0] i_b,
    input  fpn_cls_t              i_cls_a,
    input  fpn_cls_t              i_cls_b,
    input  logic                  i_unary,
    input  fpn_pol_e              i_policy,
    output logic                  o_hit,
    output logic [EXP_W+FRAC_W:0] o_result
);
    localparam int MSB   = EXP_W + FRAC_W;
    localparam int PAY_W = FRAC_W - 1;

    logic [PAY_W-1:0] pay_a;
    logic [PAY_W-1:0] pay_b;
    logic             a_wins_mag;
    logic             take_a;

    // Payload comparison for magnitude priority.
    always_comb begin
        pay_a      = i_a[PAY_W-1:0];
        pay_b      = i_b[PAY_W-1:0];
        a_wins_mag = (pay_a >= pay_b);
    end

    // Winner selection and quieted result assembly.
    always_comb begin
        if (i_unary) begin
            o_hit  = i_cls_b.is_nan;
            take_a = 1'b0;
        end else begin
            o_hit = i_cls_a.is_nan || i_cls_b.is_nan;
            if (i_cls_a.is_nan && i_cls_b.is_nan)
                take_a = (i_policy == POL_DEST) ? 1'b1 : a_wins_mag;
            else
                take_a = i_cls_a.is_nan;
        end
        o_result = take_a ? {i_a[MSB], {EXP_W{1'b1}}, 1'b1, pay_a}
                          : {i_b[MSB], {EXP_W{1'b1}}, 1'b1, pay_b};
    end
endmodule

// File: rtl/fpn_invalid_detect.sv
// Module fpn_invalid_detect
// Flags invalid operand combinations for non-NaN inputs, the negative
// zero root case, and signalling NaN inputs. Assumes the caller gives
// NaN propagation priority over these flags.
module fpn_invalid_detect
    import fpn_pkg::*;
(
    input  fpn_op_e  i_op,
    input  fpn_cls_t i_cls_a,
    input  fpn_cls_t i_cls_b,
    output logic     o_bad_op,
    output logic     o_neg_zero_root,
    output logic     o_snan
);
    logic eff_sub;

    // Classify the operand combination per opcode.
    always_comb begin
        eff_sub         = (i_op == OP_SUB) ^ (i_cls_a.sign ^ i_cls_b.sign);
        o_bad_op        = 1'b0;
        o_neg_zero_root = 1'b0;
        o_snan          = i_cls_a.is_snan || i_cls_b.is_snan;
        case (i_op)
            OP_ADD, OP_SUB:
                o_bad_op = i_cls_a.is_inf && i_cls_b.is_inf && eff_sub;
            OP_MUL:
                o_bad_op = (i_cls_a.is_inf && i_cls_b.is_zero) ||
                           (i_cls_a.is_zero && i_cls_b.is_inf);
            OP_DIV:
                o_bad_op = (i_cls_a.is_zero && i_cls_b.is_zero) ||
                           (i_cls_a.is_inf && i_cls_b.is_inf);
            OP_SQRT: begin
                o_bad_op        = i_cls_b.sign && !i_cls_b.is_zero && !i_cls_b.is_nan;
                o_neg_zero_root = i_cls_b.sign && i_cls_b.is_zero;
                o_snan          = i_cls_b.is_snan;
            end
            default: o_snan = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpn_special_resolver.sv
// Module fpn_special_resolver
// Top of the special-operand resolver. Classifies both operands, picks a
// propagated NaN or a default result, and registers result, special and
// invalid flags one clock after the input valid. Assumes opcodes 5..7 are
// unused and produce no special result. Synchronous active-low reset.
module fpn_special_resolver
    import fpn_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_valid,
    input  logic [2:0]            i_op,
    input  logic                  i_policy,
    input  logic [EXP_W+FRAC_W:0] i_a,
    input  logic [EXP_W+FRAC_W:0] i_b,
    output logic                  o_valid,
    output logic                  o_special,
    output logic                  o_invalid,
    output logic [EXP_W+FRAC_W:0] o_result
);
    localparam int W   = EXP_W + FRAC_W + 1;
    localparam int MSB = W - 1;
    localparam logic [W-1:0] DEF_NAN  = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] NEG_ZERO = {1'b1, {(W-1){1'b0}}};

    fpn_cls_t    cls_ops [2];
    fpn_op_e     op_e;
    fpn_pol_e    pol_e;
    logic        op_known;
    logic        unary;
    logic        nan_hit;
    logic [W-1:0] nan_res;
    logic        bad_op;
    logic        neg_zero_root;
    logic        snan_in;
    logic        nx_special;
    logic        nx_invalid;
    logic [W-1:0] nx_result;

    // Decode opcode and policy into typed values.
    always_comb begin
        op_e     = fpn_op_e'(i_op);
        pol_e    = fpn_pol_e'(i_policy);
        op_known = (i_op <= 3'd4);
        unary    = (i_op == 3'd4);
    end

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpn_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .i_val (g == 0 ? i_a : i_b),
            .o_cls (cls_ops[g])
        );
    end

    fpn_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
        .i_a      (i_a),
        .i_b      (i_b),
        .i_cls_a  (cls_ops[0]),
        .i_cls_b  (cls_ops[1]),
        .i_unary  (unary),
        .i_policy (pol_e),
        .o_hit    (nan_hit),
        .o_result (nan_res)
    );

    fpn_invalid_detect u_inv (
        .i_op            (op_e),
        .i_cls_a         (cls_ops[0]),
        .i_cls_b         (cls_ops[1]),
        .o_bad_op        (bad_op),
        .o_neg_zero_root (neg_zero_root),
        .o_snan          (snan_in)
    );

    // Priority: NaN propagation, then invalid default, then -0 root.
    always_comb begin
        nx_special = 1'b0;
        nx_invalid = 1'b0;
        nx_result  = '0;
        if (op_known) begin
            if (nan_hit) begin
                nx_special = 1'b1;
                nx_invalid = snan_in;
                nx_result  = nan_res;
            end else if (bad_op) begin
                nx_special = 1'b1;
                nx_invalid = 1'b1;
                nx_result  = DEF_NAN;
            end else if (neg_zero_root) begin
                nx_special = 1'b1;
                nx_result  = NEG_ZERO;
            end
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_special <= 1'b0;
            o_invalid <= 1'b0;
            o_result  <= '0;
        end else begin
            o_valid   <= i_valid;
            o_special <= i_valid && nx_special;
            o_invalid <= i_valid && nx_invalid;
            o_result  <= i_valid ? nx_result : '0;
        end
    end

    // Output valid follows input valid by one cycle.
    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);

    // Idle cycle leaves every output cleared.
    assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> (!o_valid && !o_special && !o_invalid && o_result == '0));

    // Invalid is only reported alongside a special result.
    assert_invalid_special_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_invalid |-> o_special);

    // Any special result other than -0 is a quiet NaN.
    assert_quiet_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_special && o_result != NEG_ZERO) |->
            (&o_result[MSB-1:FRAC_W] && o_result[FRAC_W-1]));

    // Non-special outputs carry a zero result.
    assert_plain_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !o_special |-> (o_result == '0 && !o_invalid));

    // Special outputs only appear with a valid result.
    assert_special_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        o_special |-> o_valid);
endmodule

// File: tb/fpn_special_resolver_tb.sv
module fpn_special_resolver_tb;

    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] INF   = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] ZERO  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] DNAN  = 64'hFFF8_0000_0000_0000;
    localparam logic [63:0] QA    = 64'h7FF8_0000_0000_1234;
    localparam logic [63:0] QB    = 64'hFFF8_0000_0000_00AB;
    localparam logic [63:0] SA    = 64'h7FF0_0000_0000_0055;
    localparam logic [63:0] SA_Q  = 64'h7FF8_0000_0000_0055;

    typedef struct packed {
        logic [2:0]  op;
        logic        pol;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic        sp;
        logic        inv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, ONE,   QB,    QB,    1'b1, 1'b0, 4'd1},  // R1 add, B NaN
        '{3'd3, 1'b1, QA,    ONE,   QA,    1'b1, 1'b0, 4'd1},  // R1 div, A NaN
        '{3'd7, 1'b0, QA,    QB,    ZERO,  1'b0, 1'b0, 4'd1},  // R1 unused opcode
        '{3'd0, 1'b0, QA,    QB,    QA,    1'b1, 1'b0, 4'd2},  // R2 A wins
        '{3'd0, 1'b0, QB,    QA,    QB,    1'b1, 1'b0, 4'd2},  // R2 swapped
        '{3'd2, 1'b1, QA,    QB,    QA,    1'b1, 1'b0, 4'd3},  // R3 larger payload
        '{3'd2, 1'b1, QB,    QA,    QA,    1'b1, 1'b0, 4'd3},  // R3 order free
        '{3'd3, 1'b1, 64'hFFF8_0000_0000_0010, 64'h7FF8_0000_0000_0010,
                      64'hFFF8_0000_0000_0010, 1'b1, 1'b0, 4'd3},  // R3 tie to A
        '{3'd1, 1'b1, 64'h7FF0_0000_0000_0001, DNAN,
                      64'h7FF8_0000_0000_0001, 1'b1, 1'b1, 4'd3},  // R3 quiet bit excluded
        '{3'd4, 1'b0, QA,    QB,    QB,    1'b1, 1'b0, 4'd4},  // R4 root of NaN
        '{3'd4, 1'b0, QA,    ONE,   ZERO,  1'b0, 1'b0, 4'd4},  // R4 A ignored
        '{3'd2, 1'b0, INF,   ZERO,  DNAN,  1'b1, 1'b1, 4'd5},  // R5
        '{3'd2, 1'b1, NZERO, NINF,  DNAN,  1'b1, 1'b1, 4'd5},  // R5 reversed
        '{3'd0, 1'b0, INF,   NINF,  DNAN,  1'b1, 1'b1, 4'd6},  // R6 add opposite
        '{3'd1, 1'b0, NINF,  NINF,  DNAN,  1'b1, 1'b1, 4'd6},  // R6 sub same
        '{3'd0, 1'b0, INF,   INF,   ZERO,  1'b0, 1'b0, 4'd6},  // R6 not special
        '{3'd1, 1'b0, INF,   NINF,  ZERO,  1'b0, 1'b0, 4'd6},  // R6 sub opposite
        '{3'd3, 1'b0, ZERO,  NZERO, DNAN,  1'b1, 1'b1, 4'd7},  // R7 0/0
        '{3'd3, 1'b0, NINF,  INF,   DNAN,  1'b1, 1'b1, 4'd7},  // R7 inf/inf
        '{3'd4, 1'b0, ZERO,  NONE,  DNAN,  1'b1, 1'b1, 4'd8},  // R8 negative
        '{3'd4, 1'b1, ZERO,  NINF,  DNAN,  1'b1, 1'b1, 4'd8},  // R8 -inf
        '{3'd4, 1'b0, ZERO,  NZERO, NZERO, 1'b1, 1'b0, 4'd8},  // R8 -0
        '{3'd2, 1'b0, SA,    ONE,   SA_Q,  1'b1, 1'b1, 4'd9},  // R9 sNaN
        '{3'd2, 1'b0, INF,   QA,    QA,    1'b1, 1'b0, 4'd9},  // R9 NaN over invalid
        '{3'd4, 1'b0, ZERO,  SA,    SA_Q,  1'b1, 1'b1, 4'd9},  // R9 root sNaN
        '{3'd3, 1'b0, ONE,   ZERO,  ZERO,  1'b0, 1'b0, 4'd10}  // R10 plain
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [2:0]  i_op = 3'd0;
    logic        i_policy = 1'b0;
    logic [63:0] i_a = '0;
    logic [63:0] i_b = '0;
    logic        o_valid;
    logic        o_special;
    logic        o_invalid;
    logic [63:0] o_result;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpn_special_resolver u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .i_valid   (i_valid),
        .i_op      (i_op),
        .i_policy  (i_policy),
        .i_a       (i_a),
        .i_b       (i_b),
        .o_valid   (o_valid),
        .o_special (o_special),
        .o_invalid (o_invalid),
        .o_result  (o_result)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic pol,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        i_op = op; i_policy = pol; i_a = a; i_b = b; i_valid = 1'b1;
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs clear under reset
        check("R12 reset valid",   {63'd0, o_valid},   64'd0);
        check("R12 reset special", {63'd0, o_special}, 64'd0);
        check("R12 reset result",  o_result,           64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].pol, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), o_result, VECS[i].res);
            check($sformatf("R%0d vec %0d special", VECS[i].req, i),
                  {63'd0, o_special}, {63'd0, VECS[i].sp});
            check($sformatf("R%0d vec %0d invalid", VECS[i].req, i),
                  {63'd0, o_invalid}, {63'd0, VECS[i].inv});
            check($sformatf("R11 vec %0d valid", i), {63'd0, o_valid}, 64'd1);
        end

        // R11: latency and idle clearing
        @(negedge clk);
        i_op = 3'd2; i_a = INF; i_b = ZERO; i_valid = 1'b1;
        check("R11 valid not early", {63'd0, o_valid}, 64'd0);
        @(negedge clk);
        i_valid = 1'b0;
        check("R11 valid after one", {63'd0, o_valid}, 64'd1);
        check("R11 result after one", o_result, DNAN);
        @(negedge clk);
        check("R11 idle valid",   {63'd0, o_valid},   64'd0);
        check("R11 idle special", {63'd0, o_special}, 64'd0);
        check("R11 idle result",  o_result,           64'd0);

        // R12: reset overrides a simultaneous valid
        @(negedge clk);
        i_op = 3'd0; i_a = QA; i_b = QB; i_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        i_valid = 1'b0;
        check("R12 reset wins valid",  {63'd0, o_valid},   64'd0);
        check("R12 reset wins result", o_result,           64'd0);
        check("R12 reset wins inv",    {63'd0, o_invalid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule